// File: doc/BRIEF.md
# Interrupt File with Top-Claim Register

This block is a message-signalled interrupt file for a single privilege level. It holds one pending bit and one enable bit for each interrupt identity from 1 to NUM_IDS-1, and a threshold register. A message write sets a pending bit by identity. A top register reports the highest-priority identity that is both pending and enabled and is not masked by the threshold. A lower identity number has higher priority.

Software services interrupts through a simple CSR port. Reads are combinational, so a single access that both reads and writes the top register returns the identity it claims in the same cycle that the write is presented. The write clears that identity's pending bit at the next clock edge. The data of the write is never stored. The next read then shows the next identity in priority order, or zero. The interrupt-request output follows the top register combinationally.

Top module: `irq_file_top`

## Requirements
- R1: After reset the pending array, the enable array and the threshold are all zero, the top register reads zero and irq_o is low.
- R2: The top register (address 0x00) reads the lowest-numbered identity whose pending and enable bits are both set. The identity appears in bits 26:16 and again in bits 10:0, and all other bits are zero. The register reads zero when no identity is both pending and enabled.
- R3: The threshold register (address 0x01) holds 11 bits, and its upper read bits are zero. When it is nonzero, the top register reads zero unless the lowest pending-and-enabled identity is less than the threshold. A threshold of zero masks nothing.
- R4: A write to the top register ignores its data. It clears only the pending bit of the identity that the register reports in that cycle. The next read reports the next pending-and-enabled identity, or zero.
- R5: A write to the top register while it reads zero leaves the pending array unchanged.
- R6: A message write (msi_vld_i with msi_id_i) sets the pending bit of identities 1 to NUM_IDS-1 at the next edge. Identity 0, and any identity of NUM_IDS or above, is ignored.
- R7: When a message write sets the same identity that a claim clears in the same cycle, the pending bit ends up set.
- R8: The pending and enable bits of identity 0 always read as zero, and writes to them are ignored.
- R9: irq_o is high exactly when the top register reads nonzero, and it changes in the same cycle as the state it depends on.
- R10: Pending word k is at address 0x10+k and enable word k is at address 0x20+k. Bit j of word k is identity 32k+j. Both arrays are readable and writable, and a write replaces the whole word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_sel_i | input | 6 | CSR address |
| csr_wr_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | Combinational CSR read data for csr_sel_i |
| msi_vld_i | input | 1 | Message write strobe |
| msi_id_i | input | 11 | Identity carried by the message write |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data and irq_o are combinational functions of the stored state. A value read in a given cycle therefore reflects every write and message that took effect at the previous rising edge. The bench drives inputs just after a falling edge and samples one nanosecond later, in the same low phase. Each CSR write or message is held for exactly one rising edge, so its effect is due on the read that follows. A combined claim samples csr_rdata_o while the write strobe is still high, before the edge that clears the bit. A reference model in the bench is updated at the same edge to supply the expected values.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    localparam int CSR_AW      = 6;
    localparam int CSR_DW      = 32;
    localparam int TOP_HI_LSB  = 16;

    localparam logic [CSR_AW-1:0] SEL_TOP   = 6'h00;
    localparam logic [CSR_AW-1:0] SEL_THR   = 6'h01;
    localparam logic [CSR_AW-1:0] SEL_PEND0 = 6'h10;
    localparam logic [CSR_AW-1:0] SEL_EN0   = 6'h20;
endpackage

// File: rtl/irqf_prio_enc.sv
module irqf_prio_enc #(
    parameter int N   = 64,
    parameter int IDW = 11
) (
    input  logic [N-1:0]   req_i,
    output logic [IDW-1:0] id_o,
    output logic           found_o
);
    always_comb begin
        id_o    = '0;
        found_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                id_o    = IDW'(i);
                found_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irqf_thr_gate.sv
module irqf_thr_gate #(
    parameter int IDW = 11
) (
    input  logic [IDW-1:0] cand_i,
    input  logic           found_i,
    input  logic [IDW-1:0] thr_i,
    output logic [IDW-1:0] top_o
);
    logic pass;
    always_comb begin
        pass  = found_i && ((thr_i == '0) || (cand_i < thr_i));
        top_o = pass ? cand_i : '0;
    end
endmodule

// File: rtl/irqf_csr_rdmux.sv
module irqf_csr_rdmux
    import irqf_pkg::*;
#(
    parameter int N      = 64,
    parameter int IDW    = 11,
    parameter int NWORDS = 2
) (
    input  logic [CSR_AW-1:0] sel_i,
    input  logic [IDW-1:0]    top_i,
    input  logic [IDW-1:0]    thr_i,
    input  logic [N-1:0]      pend_i,
    input  logic [N-1:0]      en_i,
    output logic [CSR_DW-1:0] rdata_o
);
    localparam int EXT_W = NWORDS * 32;

    logic [EXT_W-1:0] pend_ext;
    logic [EXT_W-1:0] en_ext;

    always_comb begin
        pend_ext = EXT_W'(pend_i);
        en_ext   = EXT_W'(en_i);
        rdata_o  = '0;
        if (sel_i == SEL_TOP) begin
            rdata_o = (CSR_DW'(top_i) << TOP_HI_LSB) | CSR_DW'(top_i);
        end else if (sel_i == SEL_THR) begin
            rdata_o = CSR_DW'(thr_i);
        end
        for (int k = 0; k < NWORDS; k++) begin
            if (sel_i == SEL_PEND0 + CSR_AW'(k)) rdata_o = pend_ext[k*32 +: 32];
            if (sel_i == SEL_EN0 + CSR_AW'(k))   rdata_o = en_ext[k*32 +: 32];
        end
    end
endmodule

// File: rtl/irq_file_top.sv
module irq_file_top
    import irqf_pkg::*;
#(
    parameter int NUM_IDS = 64,
    parameter int ID_W    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        csr_sel_i,
    input  logic              csr_wr_i,
    input  logic [31:0]       csr_wdata_i,
    output logic [31:0]       csr_rdata_o,
    input  logic              msi_vld_i,
    input  logic [ID_W-1:0]   msi_id_i,
    output logic              irq_o
);
    localparam int NWORDS = (NUM_IDS + 31) / 32;
    localparam int EXT_W  = NWORDS * 32;
    localparam int IX_W   = $clog2(NUM_IDS);

    typedef struct packed {
        logic [NUM_IDS-1:0] pend;
        logic [NUM_IDS-1:0] en;
        logic [ID_W-1:0]    thr;
    } file_state_t;

    file_state_t st_d, st_q;

    logic [ID_W-1:0] cand_id;
    logic            cand_found;
    logic [ID_W-1:0] top_id;
    logic [IX_W-1:0] top_ix;
    logic [IX_W-1:0] msi_ix;
    logic            msi_ok;
    logic            claim;
    logic [EXT_W-1:0] pend_ext, en_ext;

    irqf_prio_enc #(.N(NUM_IDS), .IDW(ID_W)) u_prio (
        .req_i   (st_q.pend & st_q.en),
        .id_o    (cand_id),
        .found_o (cand_found)
    );

    irqf_thr_gate #(.IDW(ID_W)) u_thr (
        .cand_i  (cand_id),
        .found_i (cand_found),
        .thr_i   (st_q.thr),
        .top_o   (top_id)
    );

    irqf_csr_rdmux #(.N(NUM_IDS), .IDW(ID_W), .NWORDS(NWORDS)) u_rdmux (
        .sel_i   (csr_sel_i),
        .top_i   (top_id),
        .thr_i   (st_q.thr),
        .pend_i  (st_q.pend),
        .en_i    (st_q.en),
        .rdata_o (csr_rdata_o)
    );

    assign top_ix = top_id[IX_W-1:0];
    assign msi_ix = msi_id_i[IX_W-1:0];
    assign msi_ok = msi_vld_i && (msi_id_i != '0) && (32'(msi_id_i) < NUM_IDS);
    assign claim  = csr_wr_i && (csr_sel_i == SEL_TOP);
    assign irq_o  = (top_id != '0);

    always_comb begin
        st_d     = st_q;
        pend_ext = EXT_W'(st_q.pend);
        en_ext   = EXT_W'(st_q.en);
        if (csr_wr_i) begin
            if (csr_sel_i == SEL_THR) st_d.thr = csr_wdata_i[ID_W-1:0];
            for (int k = 0; k < NWORDS; k++) begin
                if (csr_sel_i == SEL_PEND0 + CSR_AW'(k)) pend_ext[k*32 +: 32] = csr_wdata_i;
                if (csr_sel_i == SEL_EN0 + CSR_AW'(k))   en_ext[k*32 +: 32]   = csr_wdata_i;
            end
        end
        st_d.pend = pend_ext[NUM_IDS-1:0];
        st_d.en   = en_ext[NUM_IDS-1:0];
        if (claim && (top_id != '0)) st_d.pend[top_ix] = 1'b0;
        if (msi_ok) st_d.pend[msi_ix] = 1'b1;
        st_d.pend[0] = 1'b0;
        st_d.en[0]   = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CLAIM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && top_id != '0 && !(msi_ok && msi_ix == top_ix)) |=> !st_q.pend[$past(top_ix)]); // R4
    AST_CLAIM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && top_id == '0 && !msi_ok) |=> $stable(st_q.pend)); // R5
    AST_MSI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        msi_ok |=> st_q.pend[$past(msi_ix)]); // R7
    AST_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pend[0] && !st_q.en[0]); // R8
    AST_BELOW_THR: assert property (@(posedge clk) disable iff (!rst_n)
        (top_id != '0 && st_q.thr != '0) |-> top_id < st_q.thr); // R3
    AST_TOP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (top_id != '0) |-> (st_q.pend[top_ix] && st_q.en[top_ix])); // R2
    AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((st_q.pend & st_q.en) != '0)); // R9
endmodule

// File: tb/irq_file_top_tb.sv
module irq_file_top_tb;
    localparam logic [5:0] A_TOP = 6'h00, A_THR = 6'h01, A_PND = 6'h10, A_EN = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  csr_sel_i = '0;
    logic        csr_wr_i = 1'b0;
    logic [31:0] csr_wdata_i = '0;
    logic [31:0] csr_rdata_o;
    logic        msi_vld_i = 1'b0;
    logic [10:0] msi_id_i = '0;
    logic        irq_o;

    int total = 0, bad = 0;
    logic        done = 1'b0;
    logic [63:0] pm = '0, em = '0;
    logic [10:0] thr_m = '0;

    always #10 clk = ~clk;

    irq_file_top u_dut (
        .clk(clk), .rst_n(rst_n), .csr_sel_i(csr_sel_i), .csr_wr_i(csr_wr_i),
        .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
        .msi_vld_i(msi_vld_i), .msi_id_i(msi_id_i), .irq_o(irq_o)
    );

    function automatic int exp_top();
        int t = 0;
        for (int i = 63; i >= 1; i--) if (pm[i] && em[i]) t = i;
        if (thr_m != 0 && t >= int'(thr_m)) t = 0;
        return t;
    endfunction

    function automatic logic [31:0] fmt(int id);
        return (32'(id) << 16) | 32'(id);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        csr_sel_i = a;
        #1;
        d = csr_rdata_o;
    endtask

    task automatic model_write(logic [5:0] a, logic [31:0] d);
        int t;
        if (a == A_TOP) begin
            t = exp_top();
            if (t != 0) pm[t] = 1'b0;
        end else if (a == A_THR) thr_m = d[10:0];
        else if (a == A_PND || a == A_PND + 1) pm[(a - A_PND)*32 +: 32] = d;
        else if (a == A_EN || a == A_EN + 1) em[(a - A_EN)*32 +: 32] = d;
        pm[0] = 1'b0;
        em[0] = 1'b0;
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        csr_sel_i = a; csr_wdata_i = d; csr_wr_i = 1'b1;
        model_write(a, d);
        @(negedge clk);
        csr_wr_i = 1'b0;
    endtask

    task automatic msi(int id);
        @(negedge clk);
        msi_vld_i = 1'b1; msi_id_i = 11'(id);
        if (id >= 1 && id < 64) pm[id] = 1'b1;
        @(negedge clk);
        msi_vld_i = 1'b0;
    endtask

    task automatic chk_top(string req);
        logic [31:0] d;
        int e;
        rd(A_TOP, d);
        e = exp_top();
        chk(req, d, fmt(e));
        chk("R9", {31'b0, irq_o}, {31'b0, e != 0});
    endtask

    task automatic chk_arrays(string req);
        logic [31:0] d;
        for (int k = 0; k < 2; k++) begin
            rd(A_PND + 6'(k), d); chk(req, d, pm[k*32 +: 32]);
            rd(A_EN + 6'(k), d);  chk(req, d, em[k*32 +: 32]);
        end
    endtask

    task automatic claim_rw(string req);
        int e;
        @(negedge clk);
        csr_sel_i = A_TOP; csr_wdata_i = 32'hDEAD_BEEF; csr_wr_i = 1'b1;
        #1;
        e = exp_top();
        chk(req, csr_rdata_o, fmt(e));
        model_write(A_TOP, 32'hDEAD_BEEF);
        @(negedge clk);
        csr_wr_i = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_top("R1");
        chk_arrays("R1");
        rd(A_THR, d); chk("R1", d, 32'h0);

        // R10 and R8 array access, identity 0 bit forced low
        wr(A_EN, 32'hFFFF_FFFF);
        wr(A_EN + 1, 32'hA5A5_5A5A);
        wr(A_PND, 32'h0000_0003);
        wr(A_PND + 1, 32'h8000_0001);
        chk_arrays("R10");
        rd(A_PND, d); chk("R8", d, 32'h0000_0002);
        rd(A_EN, d);  chk("R8", d, 32'hFFFF_FFFE);

        // R2 sweep: single pending identity, all enabled
        wr(A_EN + 1, 32'hFFFF_FFFF);
        for (int i = 1; i < 64; i++) begin
            wr(A_PND, 0); wr(A_PND + 1, 0);
            msi(i);
            chk_top("R2");
            msi(63);
            chk_top("R2");
        end
        // R2: pending but disabled hides, then falls through to word 1
        wr(A_PND, 32'hFFFF_FFFF); wr(A_PND + 1, 32'h0000_0100);
        wr(A_EN, 32'h0);
        chk_top("R2");
        wr(A_EN + 1, 32'h0);
        chk_top("R2");

        // R6 out-of-range identities ignored
        wr(A_PND, 0); wr(A_PND + 1, 0);
        msi(0); msi(64); msi(2047);
        chk_arrays("R6");
        msi(33);
        chk_arrays("R6");

        // R3 threshold sweep with pending {5,20,40}
        wr(A_EN, 32'hFFFF_FFFF); wr(A_EN + 1, 32'hFFFF_FFFF);
        wr(A_PND, 0); wr(A_PND + 1, 0);
        msi(5); msi(20); msi(40);
        for (int t = 0; t < 64; t++) begin
            wr(A_THR, 32'(t));
            chk_top("R3");
        end
        wr(A_THR, 32'hFFFF_FFFF);
        rd(A_THR, d); chk("R3", d, 32'h0000_07FF);
        wr(A_THR, 32'd20);
        claim_rw("R3");
        chk_top("R3");
        chk_arrays("R3");
        wr(A_THR, 0);

        // R4 claim loop over every identity
        wr(A_PND, 32'hFFFF_FFFF); wr(A_PND + 1, 32'hFFFF_FFFF);
        for (int i = 1; i < 64; i++) begin
            claim_rw("R4");
        end
        chk_top("R4");
        chk_arrays("R4");
        // R4 data ignored, only top bit cleared
        wr(A_PND, 32'h0000_0F00);
        wr(A_TOP, 32'h0000_0000);
        chk_arrays("R4");
        wr(A_TOP, 32'hFFFF_FFFF);
        chk_arrays("R4");
        chk_top("R4");

        // R5 claim while top reads zero
        wr(A_PND, 32'h0000_00F0); wr(A_EN, 32'h0);
        chk_top("R5");
        wr(A_TOP, 32'h0000_0004);
        chk_arrays("R5");
        wr(A_EN, 32'hFFFF_FFFF); wr(A_THR, 32'd3);
        wr(A_TOP, 32'h0000_0004);
        chk_arrays("R5");
        wr(A_THR, 0);

        // R7 set wins against same-cycle claim
        wr(A_PND, 32'h0000_0080); wr(A_PND + 1, 0);
        @(negedge clk);
        csr_sel_i = A_TOP; csr_wr_i = 1'b1; msi_vld_i = 1'b1; msi_id_i = 11'd7;
        @(negedge clk);
        csr_wr_i = 1'b0; msi_vld_i = 1'b0;
        rd(A_PND, d); chk("R7", d, 32'h0000_0080);
        // different identity: claim of 7 clears, 9 is set
        @(negedge clk);
        csr_sel_i = A_TOP; csr_wr_i = 1'b1; msi_vld_i = 1'b1; msi_id_i = 11'd9;
        @(negedge clk);
        csr_wr_i = 1'b0; msi_vld_i = 1'b0;
        rd(A_PND, d); chk("R7", d, 32'h0000_0200);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule